// File: doc/BRIEF.md
# Multi-Sector NOR Flash Erase Sequencer

This block erases a contiguous, inclusive run of sectors in a parallel NOR flash bank. After a one-cycle `start`, it walks the sectors in ascending order. A sector whose protection bit is set is passed over. For every other sector, the block drives that family's erase command writes on a simple one-operation-per-cycle bus. It then stays silent for a fixed settle interval and polls the sector's status word until every device lane reports ready or the poll budget runs out. Each attempted sector ends with a write that returns the bank to read mode.

Two command families are supported. Family A uses a six-write sequence with unlock cycles at fixed offsets from the bank base. Family B uses three writes at the sector itself, and a timeout there is preceded by a suspend write. A timeout on any sector ends the whole request with the error flag raised. A malformed range is refused without touching the bus. Sector addresses come from a uniform stride above the bank base.

When the request finishes, the block pulses `done` for one cycle. It also reports how many protected sectors fell inside the requested range.

Top module: `nor_sector_eraser`

## Requirements
- R1: A start whose first index is negative (two's complement, sign bit set) or greater than the last index is refused. `done` pulses on the cycle after `start` with `err` high and `skip_cnt` zero, and no bus operation takes place.
- R2: A sector i with `prot_map[i]` set receives no bus operation. `skip_cnt` reports the number of set `prot_map` bits inside the range, even when the run aborts early.
- R3: Family B (`family`=1) issues 0x50, 0x20 and 0xD0 on consecutive cycles at the sector address. The sector address is BANK_BASE + i*SECT_STRIDE.
- R4: Family A (`family`=0) issues AA at base+0x555, 55 at base+0x2AA, 80 at base+0x555, AA at base+0x555 and 55 at base+0x2AA, on consecutive cycles, then 0x30 at the sector address.
- R5: Exactly DELAY_CYC idle cycles separate the last erase command write from the first status read of that sector.
- R6: Status reads at the sector address repeat every cycle. A sector is complete only when bit 7 of every 16-bit lane of `bus_rdata` is set. A read with any lane's bit 7 clear counts as not ready.
- R7: A sector whose first TIMEOUT_CYC reads are all not ready is abandoned. Family B first writes 0xB0 at the sector address, then the read-mode write follows. `err` is raised and no later sector is touched. The poll budget restarts for every sector.
- R8: Every attempted sector, whether it completes or not, ends with a read-mode write at the bank base: 0xF0 for family A, 0xFF for family B.
- R9: `done` is a one-cycle pulse. `busy` is high from the cycle after an accepted start until `done`. `err` keeps its value until the next accepted start.
- R10: Each command byte appears in bits 7:0 of every 16-bit lane of `bus_wdata`, with bits 15:8 of each lane zero.
- R11: At most one of `bus_wr`/`bus_rd` is high in a cycle, and neither is high while idle. A `start` that arrives while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request strobe |
| family | input | 1 | Command family: 0 = A, 1 = B |
| first_idx | input | IDX_W | First sector, two's complement |
| last_idx | input | IDX_W | Last sector, two's complement, inclusive |
| prot_map | input | 2**(IDX_W-1) | Protection bit per sector |
| bus_wr | output | 1 | Flash write strobe |
| bus_rd | output | 1 | Flash read strobe |
| bus_addr | output | ADDR_W | Flash word address |
| bus_wdata | output | LANES*LANE_W | Flash write data |
| bus_rdata | input | LANES*LANE_W | Flash read data, valid in the cycle `bus_rd` is high |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Refused or timed-out request |
| skip_cnt | output | IDX_W | Protected sectors inside the range |

## Verification
The bench places its poll answers right at the budget edge: ready on the last allowed read, and never ready. A design with an off-by-one poll counter would either abort a sector that should complete or read once too often. Not-ready answers always carry bit 7 in lane 0 but not in lane 1, so a design that tests only one lane finishes early and skips reads. Runs mix protected sectors with a timeout and refuse ranges with negative or reversed bounds. A `start` is injected mid-run. A design that miscounts skipped sectors, keeps walking after an abort, emits the suspend write for the wrong family, or restarts on a busy `start` produces bus operations that differ from the model's queue.

// File: rtl/nor_erase_pkg.sv
package nor_erase_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SCAN, ST_CMD, ST_SETTLE, ST_POLL, ST_SUSP, ST_RDRST, ST_FIN
  } erase_st_e;

  localparam logic FAM_A = 1'b0;
  localparam logic FAM_B = 1'b1;

  // value that puts the bank back into array-read mode
  function automatic logic [7:0] rdmode_code(input logic fam);
    return (fam == FAM_B) ? 8'hFF : 8'hF0;
  endfunction

  // suspend code issued before abandoning a family-B sector
  localparam logic [7:0] SUSPEND_CODE = 8'hB0;

endpackage

// File: rtl/nor_erase_tick.sv
module nor_erase_tick #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic hit
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end

  // hit marks the LIMIT-th cycle since the clear
  assign hit = (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/nor_erase_cmdgen.sv
module nor_erase_cmdgen
  import nor_erase_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter logic [ADDR_W-1:0] BANK_BASE = '0
) (
  input  logic              fam,
  input  logic [2:0]        step,
  input  logic [ADDR_W-1:0] sect_addr,
  output logic [ADDR_W-1:0] addr,
  output logic [7:0]        code,
  output logic              last
);
  localparam logic [ADDR_W-1:0] UNLK_HI = BANK_BASE + ADDR_W'(12'h555);
  localparam logic [ADDR_W-1:0] UNLK_LO = BANK_BASE + ADDR_W'(12'h2AA);

  always_comb begin
    addr = sect_addr;
    code = 8'h00;
    last = 1'b0;
    if (fam == FAM_B) begin
      case (step)
        3'd0: code = 8'h50;
        3'd1: code = 8'h20;
        3'd2: begin code = 8'hD0; last = 1'b1; end
        default: ;
      endcase
    end else begin
      case (step)
        3'd0: begin addr = UNLK_HI; code = 8'hAA; end
        3'd1: begin addr = UNLK_LO; code = 8'h55; end
        3'd2: begin addr = UNLK_HI; code = 8'h80; end
        3'd3: begin addr = UNLK_HI; code = 8'hAA; end
        3'd4: begin addr = UNLK_LO; code = 8'h55; end
        3'd5: begin code = 8'h30; last = 1'b1; end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/nor_erase_protcount.sv
module nor_erase_protcount #(
  parameter int IDX_W = 5,
  parameter int NSECT = 16
) (
  input  logic [NSECT-1:0] map,
  input  logic [IDX_W-1:0] lo,
  input  logic [IDX_W-1:0] hi,
  output logic [IDX_W-1:0] count
);
  logic [NSECT-1:0] in_rng;

  for (genvar i = 0; i < NSECT; i++) begin : g_rng
    assign in_rng[i] = map[i] && (IDX_W'(i) >= lo) && (IDX_W'(i) <= hi);
  end

  always_comb begin
    count = '0;
    for (int i = 0; i < NSECT; i++) count = count + IDX_W'(in_rng[i]);
  end
endmodule

// File: rtl/nor_sector_eraser.sv
module nor_sector_eraser
  import nor_erase_pkg::*;
#(
  parameter int IDX_W       = 5,
  parameter int ADDR_W      = 24,
  parameter int LANES       = 2,
  parameter int LANE_W      = 16,
  parameter logic [ADDR_W-1:0] BANK_BASE   = '0,
  parameter logic [ADDR_W-1:0] SECT_STRIDE = ADDR_W'(32'h0001_0000),
  parameter int DELAY_CYC   = 50000,
  parameter int TIMEOUT_CYC = 5000000,
  localparam int NSECT  = 1 << (IDX_W - 1),
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              family,
  input  logic [IDX_W-1:0]  first_idx,
  input  logic [IDX_W-1:0]  last_idx,
  input  logic [NSECT-1:0]  prot_map,
  output logic              bus_wr,
  output logic              bus_rd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [IDX_W-1:0]  skip_cnt
);

  function automatic logic [ADDR_W-1:0] sector_base(input logic [IDX_W-1:0] idx);
    return BANK_BASE + ADDR_W'(idx) * SECT_STRIDE;
  endfunction

  function automatic logic [DATA_W-1:0] ready_mask();
    logic [DATA_W-1:0] m = '0;
    for (int l = 0; l < LANES; l++) m[l*LANE_W + 7] = 1'b1;
    return m;
  endfunction

  erase_st_e        state;
  logic             fam_q, abort_q;
  logic [IDX_W-1:0] cur_q, last_q;
  logic [NSECT-1:0] prot_q;
  logic [2:0]       step_q;

  // named internal events
  logic req_bad, ev_accept, ev_reject, poll_ok, ev_sect_ok, ev_timeout, ev_skip, range_end;
  logic dly_hit, tmo_hit;
  logic [ADDR_W-1:0] sect_addr, cg_addr;
  logic [7:0]        cg_code, code;
  logic              cg_last;
  logic [IDX_W-1:0]  prot_in_rng;

  assign req_bad    = first_idx[IDX_W-1] || ($signed(first_idx) > $signed(last_idx));
  assign ev_accept  = (state == ST_IDLE) && start && !req_bad;
  assign ev_reject  = (state == ST_IDLE) && start && req_bad;
  assign poll_ok    = &(bus_rdata | ~ready_mask());
  assign ev_sect_ok = (state == ST_POLL) && poll_ok;
  assign ev_timeout = (state == ST_POLL) && !poll_ok && tmo_hit;
  assign range_end  = cur_q > last_q;
  assign ev_skip    = (state == ST_SCAN) && !range_end && prot_q[cur_q[IDX_W-2:0]];
  assign sect_addr  = sector_base(cur_q);

  nor_erase_protcount #(.IDX_W(IDX_W), .NSECT(NSECT)) u_pcount (
    .map(prot_map), .lo(first_idx), .hi(last_idx), .count(prot_in_rng)
  );

  nor_erase_cmdgen #(.ADDR_W(ADDR_W), .BANK_BASE(BANK_BASE)) u_cmd (
    .fam(fam_q), .step(step_q), .sect_addr(sect_addr),
    .addr(cg_addr), .code(cg_code), .last(cg_last)
  );

  nor_erase_tick #(.LIMIT(DELAY_CYC)) u_settle (
    .clk(clk), .rst_n(rst_n),
    .clr(state != ST_SETTLE), .inc(state == ST_SETTLE), .hit(dly_hit)
  );

  nor_erase_tick #(.LIMIT(TIMEOUT_CYC)) u_tmo (
    .clk(clk), .rst_n(rst_n),
    .clr(state != ST_POLL), .inc(state == ST_POLL), .hit(tmo_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      fam_q    <= FAM_A;
      abort_q  <= 1'b0;
      cur_q    <= '0;
      last_q   <= '0;
      prot_q   <= '0;
      step_q   <= '0;
      err      <= 1'b0;
      skip_cnt <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          err     <= req_bad;
          abort_q <= 1'b0;
          fam_q   <= family;
          cur_q   <= first_idx;
          last_q  <= last_idx;
          prot_q  <= prot_map;
          skip_cnt <= req_bad ? '0 : prot_in_rng;
          state   <= req_bad ? ST_FIN : ST_SCAN;
        end
        ST_SCAN: begin
          if (range_end)    state <= ST_FIN;
          else if (ev_skip) cur_q <= cur_q + 1'b1;
          else begin
            step_q <= '0;
            state  <= ST_CMD;
          end
        end
        ST_CMD: begin
          if (cg_last) state <= ST_SETTLE;
          else         step_q <= step_q + 1'b1;
        end
        ST_SETTLE: if (dly_hit) state <= ST_POLL;
        ST_POLL: begin
          if (ev_sect_ok) state <= ST_RDRST;
          else if (ev_timeout) begin
            abort_q <= 1'b1;
            state   <= (fam_q == FAM_B) ? ST_SUSP : ST_RDRST;
          end
        end
        ST_SUSP: state <= ST_RDRST;
        ST_RDRST: begin
          if (abort_q) begin
            err   <= 1'b1;
            state <= ST_FIN;
          end else begin
            cur_q <= cur_q + 1'b1;
            state <= ST_SCAN;
          end
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_wr   = 1'b0;
    bus_rd   = 1'b0;
    bus_addr = sect_addr;
    code     = 8'h00;
    case (state)
      ST_CMD:   begin bus_wr = 1'b1; bus_addr = cg_addr; code = cg_code; end
      ST_POLL:  bus_rd = 1'b1;
      ST_SUSP:  begin bus_wr = 1'b1; code = SUSPEND_CODE; end
      ST_RDRST: begin bus_wr = 1'b1; bus_addr = BANK_BASE; code = rdmode_code(fam_q); end
      default: ;
    endcase
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign bus_wdata[l*LANE_W +: LANE_W] = LANE_W'(code);
  end

  assign busy = (state != ST_IDLE) && (state != ST_FIN);
  assign done = (state == ST_FIN);

endmodule

// File: rtl/nor_sector_eraser_chk.sv
module nor_sector_eraser_chk #(
  parameter int IDX_W       = 5,
  parameter int DATA_W      = 32,
  parameter int DELAY_CYC   = 16,
  parameter int TIMEOUT_CYC = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [IDX_W-1:0]  first_idx,
  input logic [IDX_W-1:0]  last_idx,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              fam_q,
  input logic              ev_sect_ok,
  input logic              ev_timeout
);
  int unsigned since_wr;
  int unsigned rd_run;
  logic        prev_rd;
  logic        bad_req;

  assign bad_req = first_idx[IDX_W-1] || ($signed(first_idx) > $signed(last_idx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_wr <= 0;
      rd_run   <= 0;
      prev_rd  <= 1'b0;
    end else begin
      since_wr <= bus_wr ? 0 : ((since_wr < 32'hFFFF_FFF0) ? since_wr + 1 : since_wr);
      rd_run   <= bus_rd ? rd_run + 1 : 0;
      prev_rd  <= bus_rd;
    end
  end

  p_reject_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !done && bad_req) |=> (done && err && !bus_wr && !bus_rd));

  p_settle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !prev_rd) |-> (since_wr == DELAY_CYC));

  p_poll_budget_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |-> (rd_run < TIMEOUT_CYC));

  p_abort_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_timeout |=> (bus_wr && bus_wdata[7:0] == (fam_q ? 8'hB0 : 8'hF0)));

  p_readmode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sect_ok |=> (bus_wr && bus_wdata[7:0] == (fam_q ? 8'hFF : 8'hF0)));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_err_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(err));

  p_one_op_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_rd));

  p_quiet_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bus_wr && !bus_rd));

endmodule

bind nor_sector_eraser nor_sector_eraser_chk #(
  .IDX_W(IDX_W), .DATA_W(DATA_W), .DELAY_CYC(DELAY_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .first_idx(first_idx), .last_idx(last_idx),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .busy(busy), .done(done),
  .err(err), .fam_q(fam_q), .ev_sect_ok(ev_sect_ok), .ev_timeout(ev_timeout)
);

// File: tb/nor_sector_eraser_bench.sv
module nor_sector_eraser_bench;
  localparam int IDX_W = 5;
  localparam int NSECT = 16;
  localparam int DLY   = 12;
  localparam int TMO   = 20;
  localparam logic [23:0] BASE   = 24'h400000;
  localparam logic [23:0] STRIDE = 24'h008000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, start, family, bus_wr, bus_rd, busy, done, err;
  logic [IDX_W-1:0] first_idx, last_idx, skip_cnt;
  logic [NSECT-1:0] prot_map;
  logic [23:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  nor_sector_eraser #(
    .IDX_W(IDX_W), .ADDR_W(24), .LANES(2), .LANE_W(16),
    .BANK_BASE(BASE), .SECT_STRIDE(STRIDE), .DELAY_CYC(DLY), .TIMEOUT_CYC(TMO)
  ) u_nor_sector_eraser (
    .clk(clk), .rst_n(rst_n), .start(start), .family(family),
    .first_idx(first_idx), .last_idx(last_idx), .prot_map(prot_map),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .busy(busy), .done(done), .err(err), .skip_cnt(skip_cnt)
  );

  typedef struct {
    bit          rd;
    logic [23:0] addr;
    logic [31:0] data;
    int          gap;
    string       req;
  } ev_t;

  ev_t q[$];
  int  ready_after[NSECT];
  int  rd_seen[NSECT];
  int  vectors = 0, miscompares = 0, cyc = 0, last_op = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int idx_of(input logic [23:0] a);
    if (a < BASE) return -1;
    return int'((a - BASE) / STRIDE);
  endfunction

  // flash model: lane 0 always shows bit 7, lane 1 only once the sector is ready
  always_comb begin
    int i;
    i = idx_of(bus_addr);
    if (i >= 0 && i < NSECT && rd_seen[i] >= ready_after[i]) bus_rdata = 32'h0080_0080;
    else bus_rdata = 32'h0000_0080;
  end

  always @(posedge clk) begin
    if (bus_rd) begin
      int i;
      i = idx_of(bus_addr);
      if (i >= 0 && i < NSECT) rd_seen[i] <= rd_seen[i] + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // compare every bus operation against the reference queue
  always @(negedge clk) begin
    if (rst_n && (bus_wr || bus_rd)) begin
      if (q.size() == 0) begin
        check(1'b0, "R11", "unexpected bus op addr", longint'(bus_addr), 0);
      end else begin
        ev_t e;
        e = q.pop_front();
        check(bus_rd == e.rd, e.req, "op kind (1=read)", longint'(bus_rd), longint'(e.rd));
        check(bus_addr == e.addr, e.req, "address", longint'(bus_addr), longint'(e.addr));
        if (!e.rd) check(bus_wdata == e.data, "R10", "write data", longint'(bus_wdata), longint'(e.data));
        if (e.gap > 0) check(cyc - last_op == e.gap, "R5", "settle gap", cyc - last_op, e.gap);
      end
      last_op = cyc;
    end
  end

  function automatic logic [31:0] word(input logic [7:0] b);
    return {8'h00, b, 8'h00, b};
  endfunction

  task automatic push_wr(input logic [23:0] a, input logic [7:0] b, input string req);
    ev_t e;
    e.rd = 1'b0; e.addr = a; e.data = word(b); e.gap = 0; e.req = req;
    q.push_back(e);
  endtask

  task automatic push_rd(input logic [23:0] a, input int gap, input string req);
    ev_t e;
    e.rd = 1'b1; e.addr = a; e.data = '0; e.gap = gap; e.req = req;
    q.push_back(e);
  endtask

  task automatic set_ready(input int k);
    for (int i = 0; i < NSECT; i++) ready_after[i] = k;
  endtask

  task automatic run(input bit fam, input int first, input int last,
                     input logic [NSECT-1:0] prot, input bit poke);
    bit   refused, exp_err;
    int   exp_skip, w;
    logic [7:0] rdc;
    refused  = (first < 0) || (first > last);
    exp_err  = refused;
    exp_skip = 0;
    rdc      = fam ? 8'hFF : 8'hF0;
    q.delete();
    if (!refused) begin
      for (int s = first; s <= last; s++) if (prot[s]) exp_skip++;
      for (int s = first; s <= last; s++) begin
        logic [23:0] sa;
        int k;
        if (prot[s]) continue;
        sa = BASE + 24'(s) * STRIDE;
        if (fam) begin
          push_wr(sa, 8'h50, "R3"); push_wr(sa, 8'h20, "R3"); push_wr(sa, 8'hD0, "R3");
        end else begin
          push_wr(BASE + 24'h555, 8'hAA, "R4"); push_wr(BASE + 24'h2AA, 8'h55, "R4");
          push_wr(BASE + 24'h555, 8'h80, "R4"); push_wr(BASE + 24'h555, 8'hAA, "R4");
          push_wr(BASE + 24'h2AA, 8'h55, "R4"); push_wr(sa, 8'h30, "R4");
        end
        k = ready_after[s];
        if (k < TMO) begin
          push_rd(sa, DLY + 1, "R6");
          for (int j = 0; j < k; j++) push_rd(sa, 0, "R6");
          push_wr(BASE, rdc, "R8");
        end else begin
          push_rd(sa, DLY + 1, "R7");
          for (int j = 1; j < TMO; j++) push_rd(sa, 0, "R7");
          if (fam) push_wr(sa, 8'hB0, "R7");
          push_wr(BASE, rdc, "R8");
          exp_err = 1'b1;
          break;
        end
      end
    end
    @(negedge clk);
    for (int i = 0; i < NSECT; i++) rd_seen[i] <= 0;
    family    = fam;
    first_idx = IDX_W'(first);
    last_idx  = IDX_W'(last);
    prot_map  = prot;
    start     = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (refused) begin
      check(done == 1'b1, "R1", "done one cycle after refused start", longint'(done), 1);
    end else begin
      check(busy == 1'b1, "R9", "busy after accepted start", longint'(busy), 1);
    end
    if (poke) begin
      repeat (3) @(negedge clk);
      family = ~fam; first_idx = '0; last_idx = '0; prot_map = '0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    w = 0;
    while (!done && w < 3000) begin
      @(negedge clk);
      w++;
    end
    check(done == 1'b1, "R9", "done reached", longint'(done), 1);
    check(err == exp_err, refused ? "R1" : "R7", "err at done", longint'(err), longint'(exp_err));
    check(skip_cnt == IDX_W'(exp_skip), "R2", "skip count", longint'(skip_cnt), exp_skip);
    check(q.size() == 0, "R7", "unissued bus ops", q.size(), 0);
    check(busy == 1'b0, "R9", "busy with done", longint'(busy), 0);
    @(negedge clk);
    check(done == 1'b0, "R9", "done width", longint'(done), 0);
    repeat (4) @(negedge clk);
    check(err == exp_err, "R9", "err held after done", longint'(err), longint'(exp_err));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; family = 1'b0;
    first_idx = '0; last_idx = '0; prot_map = '0;
    set_ready(0);
    for (int i = 0; i < NSECT; i++) rd_seen[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check(busy == 0 && done == 0, "R9", "busy/done after reset", longint'({busy, done}), 0);
    check(err == 0 && skip_cnt == 0, "R2", "err/skip after reset", longint'({err, skip_cnt}), 0);
    check(!bus_wr && !bus_rd, "R11", "bus quiet after reset", longint'({bus_wr, bus_rd}), 0);

    // R4 family A plain range
    set_ready(3);
    run(1'b0, 2, 4, 16'h0000, 1'b0);
    // R3 R2 family B with protected sectors inside the range
    set_ready(0);
    run(1'b1, 0, 5, 16'h0012, 1'b0);
    // R7 family B timeout on the second sector
    set_ready(2); ready_after[4] = TMO;
    run(1'b1, 3, 6, 16'h0000, 1'b0);
    // R7 family A: last-allowed-read success, then timeout; protected sector after abort still counted
    set_ready(1); ready_after[7] = TMO - 1; ready_after[8] = TMO;
    run(1'b0, 7, 9, 16'h0200, 1'b0);
    // R1 refused requests
    set_ready(0);
    run(1'b1, 5, 3, 16'h0000, 1'b0);
    run(1'b0, -1, 4, 16'h0000, 1'b0);
    run(1'b1, -3, -1, 16'h0000, 1'b0);
    // R2 single protected sector at the top of the bank
    run(1'b0, 15, 15, 16'h8000, 1'b0);
    // R11 start while busy is ignored
    set_ready(1);
    run(1'b0, 1, 2, 16'h0000, 1'b1);
    // R6 full bank, family B, lane-split status
    run(1'b1, 0, 15, 16'h8421, 1'b0);
    // single unprotected sector
    set_ready(0);
    run(1'b1, 0, 0, 16'h0000, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule